// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge and Vector Unit

This block ties two 8-line interrupt controller slices into one 16-line unit. Lines 0 to 7 belong to the master slice and lines 8 to 15 to the slave slice. The slave slice does not own a master pin of its own. Its pending state drives master line 2. The unit keeps the request register, the in-service register and the rotation base of both slices. It also keeps the per-line trigger-mode registers, which select level or edge sensing for each line.

Two external priority resolvers read the request and in-service registers and report a winner for each slice. The unit raises the CPU interrupt output while the master has a winner. When the CPU acknowledges, the unit returns an 8-bit vector in the same cycle. On the next clock edge it records the acknowledge in the state of the slice or slices involved.

Top module: `cascade_ack_vector`

## Requirements
- R1: `cpu_int` is high exactly while `m_win_vld` is high, combinationally.
- R2: Master line 2 (request bit 2) is edge-sensed from `s_win_vld`. It is set on the clock edge after `s_win_vld` goes from 0 to 1. It is not set again while `s_win_vld` stays high.
- R3: A line with its trigger bit at 1 copies its input level into its request bit on every clock edge. A line with its trigger bit at 0 sets its request bit on a 0-to-1 input change, and the bit stays set until an acknowledge clears it. A new rising edge in the same cycle as an acknowledge of that line leaves the bit set.
- R4: An acknowledge (`ack` high for one cycle) while `m_win_vld` is high and `m_win_idx` is not 2 does three things. It drives `vector = {m_base, m_win_idx}` in that cycle. On the next edge it sets `isr[m_win_idx]`. On that same edge it clears `irr[m_win_idx]`, but only when that line is edge-sensed.
- R5: An acknowledge while the master winner is line 2 and `s_win_vld` is high acknowledges both slices. It drives `vector = {s_base, s_win_idx}`. It updates master line 2 and slave line `8+s_win_idx` by the rules of R4.
- R6: An acknowledge while the master winner is line 2 and `s_win_vld` is low drives `vector = {s_base, 3'd7}`. The master slice is updated for line 2, and the slave state is left unchanged.
- R7: An acknowledge while `m_win_vld` is low drives `vector = {m_base, 3'd7}` and changes no in-service bit, request bit or rotation base.
- R8: With a slice's auto-EOI input high, its acknowledged in-service bit ends the edge cleared. If that slice's rotate input is also high, its rotation base becomes (line + 1) mod 8. Otherwise the rotation base keeps its value.
- R9: A write with `trig_we` high stores `trig_wdata & 8'hF8` into the master trigger register (`trig_sel` = 0) or `trig_wdata & 8'hDE` into the slave trigger register (`trig_sel` = 1) on the next edge.
- R10: After reset, the request, in-service, trigger and rotation-base registers are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Line levels; bit 2 is ignored (cascade line) |
| m_win_vld | input | 1 | Master resolver has a winner |
| m_win_idx | input | 3 | Master winning line |
| s_win_vld | input | 1 | Slave resolver has a winner |
| s_win_idx | input | 3 | Slave winning line |
| m_base | input | 5 | Master vector base, upper five bits |
| s_base | input | 5 | Slave vector base, upper five bits |
| m_aeoi | input | 1 | Master auto-EOI enable |
| s_aeoi | input | 1 | Slave auto-EOI enable |
| m_rot_aeoi | input | 1 | Master rotate on auto-EOI |
| s_rot_aeoi | input | 1 | Slave rotate on auto-EOI |
| ack | input | 1 | Single-cycle acknowledge strobe |
| trig_we | input | 1 | Trigger-mode register write enable |
| trig_sel | input | 1 | Trigger register select: 0 master, 1 slave |
| trig_wdata | input | 8 | Trigger-mode write data |
| cpu_int | output | 1 | Interrupt request to the CPU |
| vector | output | 8 | Acknowledge vector |
| irr | output | 16 | Request bits, slave in the upper byte |
| isr | output | 16 | In-service bits, slave in the upper byte |
| m_prio_base | output | 3 | Master rotation base |
| s_prio_base | output | 3 | Slave rotation base |
| m_trig | output | 8 | Master trigger-mode register |
| s_trig | output | 8 | Slave trigger-mode register |

## Verification
The assertions check the following on every cycle:
- the spurious master vector, and that a spurious master acknowledge leaves the in-service register untouched;
- the in-service set, or the auto-EOI clear, of the master winner, and the master rotation update;
- the cascade edge on line 2;
- the masking of trigger-register writes.

The bench scenarios show what only ordered stimulus can reach:
- the difference between level and edge sensing on a line;
- a rising edge that coincides with an acknowledge;
- the two-slice cascade acknowledge and the spurious slave vector;
- slave auto-EOI with the rotation base wrapping from 7 to 0.

// File: rtl/cascade_ack_vector.sv
module cascade_ack_vector #(
  parameter int SLICE_W = 8,
  parameter int VEC_W = 8,
  parameter logic [SLICE_W-1:0] M_TRIG_MASK = 8'hF8,
  parameter logic [SLICE_W-1:0] S_TRIG_MASK = 8'hDE,
  parameter int CASC_LINE = 2,
  localparam int IDX_W = $clog2(SLICE_W),
  localparam int LINES = 2 * SLICE_W,
  localparam int BASE_W = VEC_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic              m_win_vld,
  input  logic [IDX_W-1:0]  m_win_idx,
  input  logic              s_win_vld,
  input  logic [IDX_W-1:0]  s_win_idx,
  input  logic [BASE_W-1:0] m_base,
  input  logic [BASE_W-1:0] s_base,
  input  logic              m_aeoi,
  input  logic              s_aeoi,
  input  logic              m_rot_aeoi,
  input  logic              s_rot_aeoi,
  input  logic              ack,
  input  logic              trig_we,
  input  logic              trig_sel,
  input  logic [SLICE_W-1:0] trig_wdata,
  output logic              cpu_int,
  output logic [VEC_W-1:0]  vector,
  output logic [LINES-1:0]  irr,
  output logic [LINES-1:0]  isr,
  output logic [IDX_W-1:0]  m_prio_base,
  output logic [IDX_W-1:0]  s_prio_base,
  output logic [SLICE_W-1:0] m_trig,
  output logic [SLICE_W-1:0] s_trig
);

  localparam logic [IDX_W-1:0] SPUR = IDX_W'(SLICE_W - 1);
  localparam logic [IDX_W-1:0] CASC = IDX_W'(CASC_LINE);

  logic [LINES-1:0] lvl, last_q, trig_all, aeoi_all, take, rise;
  logic [SLICE_W-1:0] m_oh, s_oh;
  logic m_take, casc_sel, s_take;

  assign cpu_int  = m_win_vld;
  assign casc_sel = (m_win_idx == CASC);
  assign m_take   = ack & m_win_vld;
  assign s_take   = m_take & casc_sel & s_win_vld;
  assign m_oh     = m_take ? (SLICE_W'(1) << m_win_idx) : '0;
  assign s_oh     = s_take ? (SLICE_W'(1) << s_win_idx) : '0;
  assign take     = {s_oh, m_oh};
  assign trig_all = {s_trig, m_trig};
  assign aeoi_all = {{SLICE_W{s_aeoi}}, {SLICE_W{m_aeoi}}};

  always_comb begin
    lvl = irq_in;
    lvl[CASC_LINE] = s_win_vld;
  end

  assign rise = lvl & ~last_q;

  always_comb begin
    if (!m_win_vld)
      vector = {m_base, SPUR};
    else if (casc_sel)
      vector = s_win_vld ? {s_base, s_win_idx} : {s_base, SPUR};
    else
      vector = {m_base, m_win_idx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr    <= '0;
      isr    <= '0;
      last_q <= '0;
    end else begin
      last_q <= lvl;
      isr    <= (isr & ~take) | (take & ~aeoi_all);
      irr    <= (trig_all & lvl) | (~trig_all & ((irr & ~take) | rise));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prio_base <= '0;
      s_prio_base <= '0;
    end else begin
      if (m_take && m_aeoi && m_rot_aeoi)
        m_prio_base <= m_win_idx + IDX_W'(1);
      if (s_take && s_aeoi && s_rot_aeoi)
        s_prio_base <= s_win_idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_trig <= '0;
      s_trig <= '0;
    end else if (trig_we) begin
      if (trig_sel)
        s_trig <= trig_wdata & S_TRIG_MASK;
      else
        m_trig <= trig_wdata & M_TRIG_MASK;
    end
  end

endmodule

// File: rtl/cascade_ack_vector_chk.sv
module cascade_ack_vector_chk #(
  parameter int SLICE_W = 8,
  parameter int VEC_W = 8,
  parameter logic [SLICE_W-1:0] M_TRIG_MASK = 8'hF8,
  parameter logic [SLICE_W-1:0] S_TRIG_MASK = 8'hDE,
  parameter int CASC_LINE = 2,
  localparam int IDX_W = $clog2(SLICE_W),
  localparam int LINES = 2 * SLICE_W,
  localparam int BASE_W = VEC_W - IDX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic              m_win_vld,
  input logic [IDX_W-1:0]  m_win_idx,
  input logic              s_win_vld,
  input logic [BASE_W-1:0] m_base,
  input logic              m_aeoi,
  input logic              m_rot_aeoi,
  input logic              trig_we,
  input logic              trig_sel,
  input logic [SLICE_W-1:0] trig_wdata,
  input logic [VEC_W-1:0]  vector,
  input logic [LINES-1:0]  irr,
  input logic [LINES-1:0]  isr,
  input logic [IDX_W-1:0]  m_prio_base,
  input logic [SLICE_W-1:0] m_trig,
  input logic [SLICE_W-1:0] s_trig
);

  logic s_prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s_prev <= 1'b0;
    else        s_prev <= s_win_vld;

  p_spur_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !m_win_vld) |-> (vector == {m_base, {IDX_W{1'b1}}}));

  p_spur_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !m_win_vld) |=> (isr == $past(isr)));

  p_isr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && m_win_vld && !m_aeoi) |=> isr[$past(m_win_idx)]);

  p_aeoi_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && m_win_vld && m_aeoi) |=> !isr[$past(m_win_idx)]);

  p_rot_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && m_win_vld && m_aeoi && m_rot_aeoi) |=>
      (m_prio_base == IDX_W'($past(m_win_idx) + IDX_W'(1))));

  p_casc_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_win_vld && !s_prev) |=> irr[CASC_LINE]);

  p_trig_m_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && !trig_sel) |=> (m_trig == ($past(trig_wdata) & M_TRIG_MASK)));

  p_trig_s_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && trig_sel) |=> (s_trig == ($past(trig_wdata) & S_TRIG_MASK)));

endmodule

bind cascade_ack_vector cascade_ack_vector_chk #(
  .SLICE_W(SLICE_W), .VEC_W(VEC_W), .M_TRIG_MASK(M_TRIG_MASK),
  .S_TRIG_MASK(S_TRIG_MASK), .CASC_LINE(CASC_LINE)
) u_chk (.*);

// File: tb/tb_cascade_ack_vector.sv
`timescale 1ns/1ps
module tb_cascade_ack_vector;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [15:0] irq_in;
  logic m_win_vld, s_win_vld, m_aeoi, s_aeoi, m_rot_aeoi, s_rot_aeoi, ack;
  logic trig_we, trig_sel;
  logic [2:0] m_win_idx, s_win_idx;
  logic [4:0] m_base, s_base;
  logic [7:0] trig_wdata;
  logic cpu_int;
  logic [7:0] vector, m_trig, s_trig;
  logic [15:0] irr, isr;
  logic [2:0] m_prio_base, s_prio_base;

  cascade_ack_vector dut (.*);

  int checks = 0;
  int errors = 0;
  string tag = "R10";

  bit [15:0] e_irr, e_isr, e_last;
  bit [7:0] e_mt, e_st;
  int e_mp, e_sp;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_vec();
    int mb = m_base * 8;
    int sb = s_base * 8;
    if (!m_win_vld) return mb + 7;
    if (m_win_idx == 3'd2) return s_win_vld ? sb + int'(s_win_idx) : sb + 7;
    return mb + int'(m_win_idx);
  endfunction

  task automatic compare_all();
    chk("cpu_int(R1)", 32'(cpu_int), 32'(m_win_vld));
    chk("vector", 32'(vector), 32'(exp_vec()));
    chk("irr", 32'(irr), 32'(e_irr));
    chk("isr", 32'(isr), 32'(e_isr));
    chk("m_trig", 32'(m_trig), 32'(e_mt));
    chk("s_trig", 32'(s_trig), 32'(e_st));
    chk("m_prio_base", 32'(m_prio_base), 32'(e_mp));
    chk("s_prio_base", 32'(s_prio_base), 32'(e_sp));
  endtask

  task automatic model_step();
    bit [15:0] tk = '0;
    if (ack && m_win_vld) begin
      tk[m_win_idx] = 1'b1;
      if (m_win_idx == 3'd2 && s_win_vld) tk[8 + int'(s_win_idx)] = 1'b1;
      if (m_aeoi && m_rot_aeoi) e_mp = (int'(m_win_idx) + 1) % 8;
      if (m_win_idx == 3'd2 && s_win_vld && s_aeoi && s_rot_aeoi)
        e_sp = (int'(s_win_idx) + 1) % 8;
    end
    for (int i = 0; i < 16; i++) begin
      bit lv = (i == 2) ? s_win_vld : irq_in[i];
      bit tr = (i < 8) ? e_mt[i] : e_st[i-8];
      bit ae = (i < 8) ? m_aeoi : s_aeoi;
      if (tk[i]) e_isr[i] = !ae;
      if (tr) e_irr[i] = lv;
      else if (lv && !e_last[i]) e_irr[i] = 1'b1;
      else if (tk[i]) e_irr[i] = 1'b0;
      e_last[i] = lv;
    end
    if (trig_we) begin
      if (trig_sel) e_st = trig_wdata & 8'hDE;
      else          e_mt = trig_wdata & 8'hF8;
    end
  endtask

  task automatic tick();
    #1 compare_all();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic do_ack(input bit mv, input logic [2:0] mi);
    m_win_vld = mv; m_win_idx = mi; ack = 1'b1;
    tick();
    ack = 1'b0; m_win_vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; m_win_vld = 0; s_win_vld = 0; m_win_idx = 0; s_win_idx = 0;
    m_base = 5'h01; s_base = 5'h0E; m_aeoi = 0; s_aeoi = 0; m_rot_aeoi = 0; s_rot_aeoi = 0;
    ack = 0; trig_we = 0; trig_sel = 0; trig_wdata = '0;
    e_irr = '0; e_isr = '0; e_last = '0; e_mt = '0; e_st = '0; e_mp = 0; e_sp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    tag = "R10";
    chk("irr reset", 32'(irr), 0); chk("isr reset", 32'(isr), 0);
    chk("trig reset", 32'({m_trig, s_trig}), 0);
    chk("prio reset", 32'({m_prio_base, s_prio_base}), 0);
    tick();

    tag = "R9";
    trig_we = 1; trig_sel = 0; trig_wdata = 8'hFF; tick();
    trig_sel = 1; tick();
    trig_we = 0; tick();
    chk("master mask", 32'(m_trig), 32'h F8);
    chk("slave mask", 32'(s_trig), 32'h DE);
    trig_we = 1; trig_sel = 0; trig_wdata = 8'h08; tick();
    trig_sel = 1; trig_wdata = 8'h02; tick();
    trig_we = 0; tick();

    tag = "R3";
    irq_in[0] = 1; tick();
    chk("edge set line0", 32'(irr[0]), 1);
    irq_in[3] = 1; tick();
    chk("level line3 high", 32'(irr[3]), 1);
    irq_in[3] = 0; tick();
    chk("level line3 follows low", 32'(irr[3]), 0);
    irq_in[3] = 1; tick();

    tag = "R4";
    do_ack(1, 3'd0);
    chk("isr line0 set", 32'(isr[0]), 1);
    chk("edge irr line0 cleared", 32'(irr[0]), 0);
    do_ack(1, 3'd3);
    chk("isr line3 set", 32'(isr[3]), 1);
    chk("level irr line3 kept", 32'(irr[3]), 1);

    tag = "R7";
    m_win_vld = 0; ack = 1; #1 chk("spurious master vector", 32'(vector), 32'h0F);
    do_ack(0, 3'd5);
    chk("isr unchanged", 32'(isr), 32'h0009);

    tag = "R2";
    irq_in[12] = 1; s_win_vld = 1; s_win_idx = 3'd4; tick();
    chk("cascade line set", 32'(irr[2]), 1);
    chk("slave line12", 32'(irr[12]), 1);
    tick(); tick();

    tag = "R5";
    m_win_vld = 1; m_win_idx = 3'd2; ack = 1; #1 chk("cascade vector", 32'(vector), 32'h74);
    do_ack(1, 3'd2);
    chk("isr master2+slave12", 32'({isr[12], isr[2]}), 32'b11);
    chk("irr 2 and 12 cleared", 32'({irr[12], irr[2]}), 0);
    tag = "R2";
    tick();
    chk("no repeat cascade edge", 32'(irr[2]), 0);

    tag = "R6";
    s_win_vld = 0; tick();
    m_win_vld = 1; m_win_idx = 3'd2; ack = 1; #1 chk("spurious slave vector", 32'(vector), 32'h77);
    do_ack(1, 3'd2);
    chk("slave isr unchanged", 32'(isr[15:8]), 32'h10);
    chk("slave irr unchanged", 32'(irr[15:8]), 32'h00);

    tag = "R8";
    m_aeoi = 1; m_rot_aeoi = 1; irq_in[5] = 1; tick();
    do_ack(1, 3'd5);
    chk("aeoi isr5 clear", 32'(isr[5]), 0);
    chk("master rot base", 32'(m_prio_base), 6);
    s_aeoi = 1; s_rot_aeoi = 1; irq_in[15] = 1; s_win_vld = 1; s_win_idx = 3'd7; tick();
    do_ack(1, 3'd2);
    chk("slave aeoi isr15", 32'(isr[15]), 0);
    chk("master aeoi isr2", 32'(isr[2]), 0);
    chk("slave rot wraps", 32'(s_prio_base), 0);
    chk("master rot base 3", 32'(m_prio_base), 3);
    s_win_vld = 0; m_rot_aeoi = 0; irq_in[0] = 0; tick();
    irq_in[0] = 1; tick();
    do_ack(1, 3'd0);
    chk("rot kept without rotate", 32'(m_prio_base), 3);
    m_aeoi = 0; s_aeoi = 0;

    tag = "R3";
    irq_in[1] = 1; tick();
    irq_in[1] = 0; tick();
    irq_in[1] = 1; do_ack(1, 3'd1);
    chk("rise wins over ack clear", 32'(irr[1]), 1);
    chk("isr1 set", 32'(isr[1]), 1);

    tag = "R1";
    m_win_vld = 1; #1 chk("cpu_int high", 32'(cpu_int), 1);
    tick();
    m_win_vld = 0; #1 chk("cpu_int low", 32'(cpu_int), 0);
    tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule